// File: doc/BRIEF.md
# Write-Protected Byte-Addressable Memory

This block is a byte-organised storage array whose size is a power of two. It is meant to be treated as non-volatile. A single synchronous request port carries the address, write data, an access size code and a write strobe. Each request moves one byte, one halfword or one word. The address is always folded into the array by keeping only its low index bits, so any address is legal. A read returns its bytes in little-endian order one cycle after the request.

A configurable number of bytes at the bottom of the array is protected. A store whose folded starting address falls inside that region is dropped without trace. A separate init port writes single bytes without regard to protection, which lets the system seed the contents after power-up. Reset clears only the response registers and leaves the stored bytes as they were.

Top module: `wp_byte_ram`

## Requirements
- R1: The effective byte index is the request address ANDed with MEM_BYTES-1, so an address of MEM_BYTES+k reaches the same byte as k, for reads and for writes.
- R2: Size code 0 moves 1 byte, code 1 moves 2 bytes and code 2 moves 4 bytes. A store writes the low 8, 16 or 32 bits of req_wdata, with bits [7:0] at the lowest index and later bytes at consecutive indices. No other byte changes.
- R3: A read with a valid size raises rd_valid in the cycle after the request. rd_data holds the bytes from consecutive indices in little-endian order, with the unused upper bytes zero. A read at the top of the array continues at index 0.
- R4: A store whose masked starting index is below PROT_BYTES changes no byte.
- R5: Protection is judged on the starting index only. A store that starts at or above PROT_BYTES and runs past the top of the array writes its wrapped bytes into indices 0 and up, even when those indices are protected.
- R6: Size code 3 raises size_err for exactly the following cycle, for reads and for writes. Such a request changes no byte and does not raise rd_valid.
- R7: While rst_n is low, rd_valid and size_err are 0. Asserting reset leaves every stored byte unchanged.
- R8: init_we writes init_data at init_addr masked to the array, whether or not that index is protected. If a bus store hits the same byte in the same cycle, the init value is the one kept.
- R9: With PROT_BYTES set to 0, no index is protected, and a store to index 0 and up takes effect.
- R10: A write request never raises rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the response registers |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_addr | input | ADDR_W | Byte address, folded into the array |
| req_wdata | input | 32 | Store data, low bytes used first |
| init_we | input | 1 | Init byte write strobe |
| init_addr | input | ADDR_W | Init byte address, folded into the array |
| init_data | input | 8 | Init byte value |
| rd_valid | output | 1 | Read data valid, one cycle after a load |
| rd_data | output | 32 | Little-endian load result, zero-filled |
| size_err | output | 1 | One-cycle pulse after a request with size code 3 |

## Verification
A faulty index fold or lane offset shows on the next load of the affected bytes as shifted or misplaced data. An alias read at MEM_BYTES+k, or a store that straddles the top of the array, exposes it within two requests. A broken protection compare leaves a changed byte behind, and a later load of that byte reveals it. A response register that has picked up the wrong request type shows one cycle after that request, as a spurious or missing rd_valid or size_err.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  // Byte lanes touched by an access of the given size code.
  function automatic logic [3:0] size_lanes(input logic [1:0] code);
    case (acc_size_e'(code))
      SZ_BYTE: return 4'b0001;
      SZ_HALF: return 4'b0011;
      SZ_WORD: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic size_valid(input logic [1:0] code);
    return acc_size_e'(code) != SZ_BAD;
  endfunction

  // Expand a lane mask into a 32-bit data mask.
  function automatic logic [31:0] lanes_to_bits(input logic [3:0] lanes);
    logic [31:0] bits;
    for (int i = 0; i < 4; i++) bits[8*i +: 8] = {8{lanes[i]}};
    return bits;
  endfunction

endpackage

// File: rtl/wpr_req_decode.sv
module wpr_req_decode #(
  parameter int MEM_BYTES  = 256,
  parameter int PROT_BYTES = 16,
  parameter int ADDR_W     = 12,
  localparam int IDX_W     = $clog2(MEM_BYTES)
) (
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [IDX_W-1:0]  base_idx,
  output logic [3:0]        lane_mask,
  output logic              prot_hit,
  output logic              wr_fire,
  output logic              rd_fire,
  output logic              err_fire
);
  import wpr_pkg::*;

  logic size_good;
  logic unused_hi;

  // Masking by MEM_BYTES-1 is the same as keeping the low index bits.
  assign base_idx  = req_addr[IDX_W-1:0];
  assign unused_hi = ^req_addr[ADDR_W-1:IDX_W];
  assign size_good = size_valid(req_size);
  assign lane_mask = size_lanes(req_size);

  generate
    if (PROT_BYTES == 0) begin : g_noprot
      assign prot_hit = 1'b0;
    end else begin : g_prot
      assign prot_hit = 32'(base_idx) < 32'(PROT_BYTES);
    end
  endgenerate

  assign wr_fire  = req_valid && req_we && size_good && !prot_hit;
  assign rd_fire  = req_valid && !req_we && size_good;
  assign err_fire = req_valid && !size_good;

endmodule

// File: rtl/wpr_byte_array.sv
module wpr_byte_array #(
  parameter int MEM_BYTES = 256,
  parameter int PROBE_IDX = 0,
  localparam int IDX_W    = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             wr_fire,
  input  logic [IDX_W-1:0] base_idx,
  input  logic [3:0]       lane_mask,
  input  logic [31:0]      wdata,
  input  logic             init_we,
  input  logic [IDX_W-1:0] init_idx,
  input  logic [7:0]       init_data,
  output logic [31:0]      rd_word,
  output logic [7:0]       probe_byte
);

  logic [7:0]       mem [MEM_BYTES];
  logic [IDX_W-1:0] lane_idx [4];

  // Lane offsets wrap naturally in IDX_W bits.
  for (genvar g = 0; g < 4; g++) begin : g_lane
    localparam logic [IDX_W-1:0] OFS = IDX_W'(g);
    assign lane_idx[g]       = base_idx + OFS;
    assign rd_word[8*g +: 8] = mem[lane_idx[g]];
  end

  // No reset: contents survive it. The init write comes last so that it wins.
  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (wr_fire && lane_mask[i]) mem[lane_idx[i]] <= wdata[8*i +: 8];
    end
    if (init_we) mem[init_idx] <= init_data;
  end

  assign probe_byte = mem[PROBE_IDX];

endmodule

// File: rtl/wp_byte_ram.sv
module wp_byte_ram #(
  parameter int MEM_BYTES  = 256,
  parameter int PROT_BYTES = 16,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              init_we,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [7:0]        init_data,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              size_err
);
  import wpr_pkg::*;

  localparam int IDX_W     = $clog2(MEM_BYTES);
  localparam int PROBE_IDX = (PROT_BYTES >= 4) ? PROT_BYTES - 1 : 0;

  logic [IDX_W-1:0] base_idx;
  logic [3:0]       lane_mask;
  logic             prot_hit, wr_fire, rd_fire, err_fire;
  logic [31:0]      rd_word;
  logic [7:0]       probe_byte;
  logic             unused_init_hi;

  assign unused_init_hi = ^init_addr[ADDR_W-1:IDX_W];

  wpr_req_decode #(
    .MEM_BYTES(MEM_BYTES), .PROT_BYTES(PROT_BYTES), .ADDR_W(ADDR_W)
  ) u_dec (
    .req_valid(req_valid), .req_we(req_we), .req_size(req_size),
    .req_addr(req_addr), .base_idx(base_idx), .lane_mask(lane_mask),
    .prot_hit(prot_hit), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .err_fire(err_fire)
  );

  wpr_byte_array #(
    .MEM_BYTES(MEM_BYTES), .PROBE_IDX(PROBE_IDX)
  ) u_arr (
    .clk(clk), .wr_fire(wr_fire), .base_idx(base_idx),
    .lane_mask(lane_mask), .wdata(req_wdata), .init_we(init_we),
    .init_idx(init_addr[IDX_W-1:0]), .init_data(init_data),
    .rd_word(rd_word), .probe_byte(probe_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      size_err <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      size_err <= err_fire;
      if (rd_fire) rd_data <= rd_word & lanes_to_bits(lane_mask);
    end
  end

endmodule

// File: rtl/wpr_checker.sv
module wpr_checker #(
  parameter int PROT_BYTES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_we,
  input logic [1:0] req_size,
  input logic       init_we,
  input logic       rd_valid,
  input logic       size_err,
  input logic [7:0] probe_byte
);

  // R3: a load response follows a valid load request.
  a_r3_rd_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_we && req_size != 2'd3));

  // R6: the error pulse follows a request with the invalid size code.
  a_r6_err_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> $past(req_valid && req_size == 2'd3));

  // R6: the two responses never coincide.
  a_r6_err_excl_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !(size_err && rd_valid));

  // R10: stores produce no load response.
  a_r10_no_rd_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_we) |-> !rd_valid);

  // R7: the response registers come out of reset at zero.
  a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!rd_valid && !size_err));

  generate
    if (PROT_BYTES >= 4) begin : g_probe
      // R4: the highest protected byte moves only through the init port.
      a_r4_prot_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(init_we) |-> $stable(probe_byte));
    end
  endgenerate

endmodule

bind wp_byte_ram wpr_checker #(.PROT_BYTES(PROT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_size(req_size), .init_we(init_we), .rd_valid(rd_valid),
  .size_err(size_err), .probe_byte(probe_byte)
);

// File: tb/wp_byte_ram_bench.sv
`timescale 1ns/1ps
module wp_byte_ram_bench;
  localparam int MB = 256;
  localparam int PB = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          init_we = 1'b0;
  logic [AW-1:0] init_addr = '0;
  logic [7:0]    init_data = '0;
  logic          rd_valid, size_err, np_rd_valid, np_size_err;
  logic [31:0]   rd_data, np_rd_data;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] model [MB];

  always #2 clk = ~clk;

  wp_byte_ram #(.MEM_BYTES(MB), .PROT_BYTES(PB), .ADDR_W(AW)) u_wp_byte_ram (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .size_err(size_err));

  wp_byte_ram #(.MEM_BYTES(MB), .PROT_BYTES(0), .ADDR_W(AW)) u_wp_byte_ram_np (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
    .rd_valid(np_rd_valid), .rd_data(np_rd_data), .size_err(np_size_err));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
  endfunction

  function automatic logic [31:0] expect_rd(input int addr, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int i = 0; i < nbytes(sz); i++) v[8*i +: 8] = model[(addr + i) % MB];
    return v;
  endfunction

  // One request; outputs are sampled at the negedge after the capturing edge.
  task automatic bus(input logic we, input logic [1:0] sz, input int addr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_size = sz;
    req_addr = AW'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    if (we && nbytes(sz) != 0 && (addr % MB) >= PB)
      for (int i = 0; i < nbytes(sz); i++) model[(addr + i) % MB] = wd[8*i +: 8];
  endtask

  task automatic write(input string tag, input logic [1:0] sz, input int addr, input logic [31:0] wd);
    bus(1'b1, sz, addr, wd);
    check({tag, " R10 no rd_valid on store"}, 32'(rd_valid), 0);
  endtask

  task automatic read_chk(input string tag, input logic [1:0] sz, input int addr);
    bus(1'b0, sz, addr, 32'h0);
    check({tag, " R3 rd_valid"}, 32'(rd_valid), 1);
    check({tag, " data"}, rd_data, expect_rd(addr, sz));
  endtask

  task automatic init_byte(input int addr, input logic [7:0] d);
    @(negedge clk);
    init_we = 1'b1; init_addr = AW'(addr); init_data = d;
    @(negedge clk);
    init_we = 1'b0;
    model[addr % MB] = d;
  endtask

  task automatic t_reset;
    check("R7 rd_valid in reset", 32'(rd_valid), 0);
    check("R7 size_err in reset", 32'(size_err), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 rd_valid after reset", 32'(rd_valid), 0);
    for (int i = 0; i < MB; i++) init_byte(i, 8'(i) ^ 8'h5A);
  endtask

  task automatic t_sizes;
    read_chk("R2 byte read", 2'd0, 32'h21);
    read_chk("R2 half read", 2'd1, 32'h22);
    read_chk("R2 word read", 2'd2, 32'h24);
    write("R2 word store", 2'd2, 32'h40, 32'hDEADBEEF);
    read_chk("R2 word back", 2'd2, 32'h40);
    bus(1'b0, 2'd0, 32'h41, 0);
    check("R3 byte 0x41 zero-filled", rd_data, 32'h000000BE);
    bus(1'b0, 2'd1, 32'h42, 0);
    check("R3 half 0x42", rd_data, 32'h0000DEAD);
    write("R2 half store", 2'd1, 32'h50, 32'h12345678);
    read_chk("R2 half store keeps neighbours", 2'd2, 32'h50);
    write("R2 byte store", 2'd0, 32'h61, 32'hAABBCC77);
    read_chk("R2 byte store", 2'd2, 32'h60);
  endtask

  task automatic t_alias;
    bus(1'b0, 2'd2, 32'h40 + MB, 0);
    check("R1 alias read", rd_data, 32'hDEADBEEF);
    write("R1 alias store", 2'd1, 32'h80 + 2 * MB, 32'h0000C0DE);
    read_chk("R1 alias store landed", 2'd1, 32'h80);
  endtask

  task automatic t_protect;
    write("R4 word in region", 2'd2, 32'h08, 32'h01020304);
    read_chk("R4 region unchanged", 2'd2, 32'h08);
    write("R4 last protected byte", 2'd0, 32'h0F, 32'h000000EE);
    bus(1'b0, 2'd0, 32'h0F, 0);
    check("R4 byte 0x0F kept", rd_data, 32'(8'h0F ^ 8'h5A));
    write("R4 aliased into region", 2'd2, 32'h0C + MB, 32'h55667788);
    read_chk("R4 aliased region unchanged", 2'd2, 32'h0C);
    write("R4 boundary byte writable", 2'd0, PB, 32'h000000A5);
    bus(1'b0, 2'd0, PB, 0);
    check("R4 boundary byte", rd_data, 32'h000000A5);
  endtask

  task automatic t_wrap;
    write("R5 wrapping word", 2'd2, MB - 2, 32'hA1B2C3D4);
    bus(1'b0, 2'd1, 0, 0);
    check("R5 wrapped bytes in region", rd_data, 32'h0000A1B2);
    bus(1'b0, 2'd1, MB - 1, 0);
    check("R3 read wraps at top", rd_data, 32'h0000B2C3);
    read_chk("R5 whole wrapped word", 2'd2, MB - 2);
  endtask

  task automatic t_bad_size;
    write("R6 bad store", 2'd3, 32'h90, 32'hFFFFFFFF);
    check("R6 size_err pulse", 32'(size_err), 1);
    @(negedge clk);
    check("R6 size_err one cycle", 32'(size_err), 0);
    bus(1'b0, 2'd3, 32'h90, 0);
    check("R6 bad load no rd_valid", 32'(rd_valid), 0);
    check("R6 bad load size_err", 32'(size_err), 1);
    read_chk("R6 memory untouched", 2'd2, 32'h90);
    check("R6 size_err clear on good load", 32'(size_err), 0);
  endtask

  task automatic t_reset_keeps;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 outputs low in reset", 32'({rd_valid, size_err}), 0);
    rst_n = 1'b1;
    bus(1'b0, 2'd2, 32'h40, 0);
    check("R7 contents survive reset", rd_data, 32'hDEADBEEF);
  endtask

  task automatic t_init;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_size = 2'd0;
    req_addr = AW'(32'h70); req_wdata = 32'h11;
    init_we = 1'b1; init_addr = AW'(32'h70); init_data = 8'h99;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; init_we = 1'b0;
    model[32'h70] = 8'h99;
    bus(1'b0, 2'd0, 32'h70, 0);
    check("R8 init wins same byte", rd_data, 32'h99);
    init_byte(32'h05 + MB, 8'h77);
    bus(1'b0, 2'd0, 32'h05, 0);
    check("R8 init into protected region", rd_data, 32'h77);
  endtask

  task automatic t_noprot;
    write("R9 store at 3", 2'd0, 32'h03, 32'h0000003C);
    bus(1'b0, 2'd0, 32'h03, 0);
    check("R9 unprotected copy stores", np_rd_data, 32'h3C);
    check("R9 protected copy drops", rd_data, 32'(model[3]));
  endtask

  initial begin
    t_reset();
    t_sizes();
    t_alias();
    t_protect();
    t_wrap();
    t_bad_size();
    t_reset_keeps();
    t_init();
    t_noprot();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule